// File: doc/BRIEF.md
# Direct-Mapped Write-Back Level-Two Cache Controller

This block controls an external level-two cache that keeps its data in SRAM outside the block and its tags in a store inside it. The CPU side hands in one line request at a time: a line address and a read or write flag. The controller looks up the tag for that line. On a hit it paces four data beats on the SRAM control pins. On a miss it asks a memory-side port for a line writeback (only when the victim line is dirty) and then a line fill, and installs the new tag clean. It then replays the access, which now hits.

Two static pins shape the cache. `size_big` doubles the number of lines by taking one more address bit into the index. `std_sram` picks the beat pacing for standard, non-burst SRAM parts instead of burst parts. Both pins may change only while reset is held. A separate snoop port lets bus masters probe the tag store. A snoop write that hits invalidates the line. A snoop read that hits a dirty line flags that the line must be written back before memory answers. The SRAM enable drops whenever no beat sequence is running, which gives the SRAM a low-power standby state.

The request, memory-request and snoop inputs use valid/ready handshakes. The master holds valid, and every field that goes with it, steady until it sees ready high at a clock edge. A transfer happens at the first edge where valid and ready are both high. Data beats, the SRAM pins, `mem_done` and the snoop response are plain signals with fixed timing and no back-pressure.

Top module: `l2dm_ctrl`

## Requirements
- R1: After reset is released, `req_ready` and `snp_ready` stay low for exactly 2^(IDX_W+1) clock edges while the tag store clears one entry per cycle. They then rise, and every entry reads as invalid.
- R2: The line address splits into an index and a tag. With `size_big`=0 the index is bits [IDX_W-1:0] and bit IDX_W is forced to zero. With `size_big`=1 the index is bits [IDX_W:0]. The tag is always bits [LA_W-1:IDX_W]. So in the small setting, two addresses that differ only in bit IDX_W evict each other.
- R3: A request whose tag matches a valid entry raises no memory request. A write that hits marks the line dirty and sends nothing to memory.
- R4: With `std_sram`=0, a hit raises `beat_o` in cycles 3, 4, 5 and 6, counting the request handshake cycle as cycle 1. This holds for reads and for writes.
- R5: With `std_sram`=1, a read hit raises `beat_o` in cycles 3, 5, 7 and 9. A write hit raises it in cycles 4, 6, 8 and 10. After a miss, the replayed beats keep the same spacing.
- R6: A miss on an invalid or clean line raises one fill request (`mem_req_wb`=0) at the requested line address. After the following `mem_done` pulse, the line is valid and clean and the access completes as a hit.
- R7: A miss on a dirty line first raises a writeback request (`mem_req_wb`=1) at the victim address, formed as the stored tag followed by the low IDX_W index bits. It waits for `mem_done`, then raises the fill request of R6.
- R8: A memory request stays valid, with a stable address and type, until `mem_req_ready` is seen high.
- R9: `sram_en` is high only while a beat sequence runs. `sram_we` is high only while a write runs. `beat_idx` counts 0 to 3 across the four beats.
- R10: A snoop accepted at an edge gives `snp_rsp_valid` in the next cycle only. `snp_hit` is high in that response when the snoop tag matches a valid entry.
- R11: A snoop write that hits clears the entry's valid bit and reports `snp_wb_needed`=0.
- R12: A snoop read that hits a dirty line reports `snp_wb_needed`=1 and leaves the entry unchanged.
- R13: `req_ready` is high only when the controller is idle and clearing has finished. It is never high while a beat sequence or a memory request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_big | input | 1 | 1 = double line count (extra index bit) |
| std_sram | input | 1 | 1 = standard SRAM pacing, 0 = burst SRAM pacing |
| req_valid | input | 1 | CPU line request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | LA_W | Requested line address |
| req_write | input | 1 | 1 = write request |
| beat_o | output | 1 | One data beat transfers this cycle |
| beat_idx | output | $clog2(BEATS) | Beat number within the line |
| sram_en | output | 1 | SRAM enable; low means standby |
| sram_we | output | 1 | SRAM write enable |
| mem_req_valid | output | 1 | Memory-side line request valid |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_wb | output | 1 | 1 = writeback, 0 = fill |
| mem_req_addr | output | LA_W | Line address of the memory request |
| mem_done | input | 1 | Pulse: the accepted line transfer finished |
| snp_valid | input | 1 | Snoop query valid |
| snp_ready | output | 1 | Snoop can be accepted |
| snp_addr | input | LA_W | Snooped line address |
| snp_write | input | 1 | 1 = bus-master write |
| snp_rsp_valid | output | 1 | Snoop result valid |
| snp_hit | output | 1 | Snooped line present |
| snp_wb_needed | output | 1 | Dirty line must be written back first |

## Verification
The hardest state to reach is a dirty victim whose tag is stale against the request. It needs a fill, then a write hit, then a request to a different tag at the same index. In the small setting it also needs two addresses that alias only through bit IDX_W. The bench builds this by walking every index in all four combinations of size and pacing. At each index it runs a fixed chain of fills, write hits, snoop probes, an invalidation and an aliasing request. A small memory stub answers with a delayed `mem_done`, so the order of writeback and fill, the victim address and the beat spacing of the replay can all be compared with a model of the tag store that the bench keeps itself.

// File: rtl/l2dm_pkg.sv
package l2dm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_XFER,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } l2dm_state_e;

endpackage

// File: rtl/l2dm_tag_ram.sv
module l2dm_tag_ram #(
  parameter int IDX_BITS = 7,
  parameter int TAG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                busy_o,
  input  logic [IDX_BITS-1:0] cpu_idx,
  output logic                cpu_v,
  output logic                cpu_d,
  output logic [TAG_W-1:0]    cpu_t,
  input  logic                cpu_we,
  input  logic                cpu_wr_dirty,
  input  logic [TAG_W-1:0]    cpu_wr_tag,
  input  logic [IDX_BITS-1:0] snp_idx,
  output logic                snp_v,
  output logic                snp_d,
  output logic [TAG_W-1:0]    snp_t,
  input  logic                snp_inv
);
  localparam int DEPTH = 1 << IDX_BITS;
  localparam logic [IDX_BITS-1:0] LAST = IDX_BITS'(DEPTH - 1);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] dty_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IDX_BITS-1:0] sweep_q;
  logic busy_q;

  assign busy_o = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_q <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == LAST) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      vld_q[sweep_q] <= 1'b0;
    end else begin
      if (cpu_we) begin
        vld_q[cpu_idx] <= 1'b1;
        dty_q[cpu_idx] <= cpu_wr_dirty;
        tag_q[cpu_idx] <= cpu_wr_tag;
      end
      if (snp_inv && !(cpu_we && cpu_idx == snp_idx))
        vld_q[snp_idx] <= 1'b0;
    end
  end

  assign cpu_v = vld_q[cpu_idx];
  assign cpu_d = dty_q[cpu_idx];
  assign cpu_t = tag_q[cpu_idx];
  assign snp_v = vld_q[snp_idx];
  assign snp_d = dty_q[snp_idx];
  assign snp_t = tag_q[snp_idx];

endmodule

// File: rtl/l2dm_beat_seq.sv
module l2dm_beat_seq #(
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     std_i,
  input  logic                     write_i,
  output logic                     active_o,
  output logic                     beat_o,
  output logic [$clog2(BEATS)-1:0] idx_o,
  output logic                     last_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] FINAL = BEAT_W'(BEATS - 1);

  logic              active_q;
  logic              wait_q;
  logic [BEAT_W-1:0] num_q;

  assign active_o = active_q;
  assign beat_o   = active_q && !wait_q;
  assign last_o   = beat_o && (num_q == FINAL);
  assign idx_o    = num_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      num_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      num_q    <= '0;
      wait_q   <= std_i && write_i;
    end else if (beat_o) begin
      if (last_o) begin
        active_q <= 1'b0;
      end else begin
        num_q  <= num_q + 1'b1;
        wait_q <= std_i;
      end
    end else if (active_q) begin
      wait_q <= 1'b0;
    end
  end

endmodule

// File: rtl/l2dm_ctrl.sv
module l2dm_ctrl
  import l2dm_pkg::*;
#(
  parameter int LA_W  = 12,
  parameter int IDX_W = 6,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     size_big,
  input  logic                     std_sram,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LA_W-1:0]          req_addr,
  input  logic                     req_write,
  output logic                     beat_o,
  output logic [$clog2(BEATS)-1:0] beat_idx,
  output logic                     sram_en,
  output logic                     sram_we,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_wb,
  output logic [LA_W-1:0]          mem_req_addr,
  input  logic                     mem_done,
  input  logic                     snp_valid,
  output logic                     snp_ready,
  input  logic [LA_W-1:0]          snp_addr,
  input  logic                     snp_write,
  output logic                     snp_rsp_valid,
  output logic                     snp_hit,
  output logic                     snp_wb_needed
);
  localparam int IDX_BITS = IDX_W + 1;
  localparam int TAG_W    = LA_W - IDX_W;

  function automatic logic [IDX_BITS-1:0] idx_of(input logic [LA_W-1:0] a, input logic big);
    return big ? a[IDX_W:0] : {1'b0, a[IDX_W-1:0]};
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LA_W-1:0] a);
    return a[LA_W-1:IDX_W];
  endfunction

  l2dm_state_e state_q, state_d;
  logic [LA_W-1:0] addr_q;
  logic            write_q;

  logic                busy;
  logic [IDX_BITS-1:0] cur_idx, s_idx;
  logic [TAG_W-1:0]    cur_tag, s_tag, cpu_t, snp_t;
  logic                cpu_v, cpu_d, snp_v, snp_d;
  logic                cpu_hit, s_hit, s_acc, s_inv;
  logic                cpu_we, cpu_wr_dirty;
  logic                seq_start, seq_active, seq_last;

  assign cur_idx = idx_of(addr_q, size_big);
  assign cur_tag = tag_of(addr_q);
  assign s_idx   = idx_of(snp_addr, size_big);
  assign s_tag   = tag_of(snp_addr);
  assign cpu_hit = cpu_v && (cpu_t == cur_tag);
  assign s_hit   = snp_v && (snp_t == s_tag);

  l2dm_tag_ram #(.IDX_BITS(IDX_BITS), .TAG_W(TAG_W)) tags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy),
    .cpu_idx     (cur_idx),
    .cpu_v       (cpu_v),
    .cpu_d       (cpu_d),
    .cpu_t       (cpu_t),
    .cpu_we      (cpu_we),
    .cpu_wr_dirty(cpu_wr_dirty),
    .cpu_wr_tag  (cur_tag),
    .snp_idx     (s_idx),
    .snp_v       (snp_v),
    .snp_d       (snp_d),
    .snp_t       (snp_t),
    .snp_inv     (s_inv)
  );

  l2dm_beat_seq #(.BEATS(BEATS)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (seq_start),
    .std_i   (std_sram),
    .write_i (write_q),
    .active_o(seq_active),
    .beat_o  (beat_o),
    .idx_o   (beat_idx),
    .last_o  (seq_last)
  );

  assign req_ready = (state_q == ST_IDLE) && !busy;
  assign snp_ready = !busy && ((state_q == ST_IDLE) || (state_q == ST_XFER));
  assign sram_en   = seq_active;
  assign sram_we   = seq_active && write_q;

  always_comb begin
    state_d      = state_q;
    seq_start    = 1'b0;
    cpu_we       = 1'b0;
    cpu_wr_dirty = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_wb   = 1'b0;
    mem_req_addr = addr_q;
    case (state_q)
      ST_IDLE: if (req_valid && req_ready) state_d = ST_LOOK;
      ST_LOOK: begin
        if (cpu_hit) begin
          seq_start = 1'b1;
          state_d   = ST_XFER;
          if (write_q) begin
            cpu_we       = 1'b1;
            cpu_wr_dirty = 1'b1;
          end
        end else if (cpu_v && cpu_d) begin
          state_d = ST_WB_REQ;
        end else begin
          state_d = ST_FILL_REQ;
        end
      end
      ST_XFER: if (seq_last) state_d = ST_IDLE;
      ST_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_wb    = 1'b1;
        mem_req_addr  = {cpu_t, cur_idx[IDX_W-1:0]};
        if (mem_req_ready) state_d = ST_WB_WAIT;
      end
      ST_WB_WAIT: if (mem_done) state_d = ST_FILL_REQ;
      ST_FILL_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_done) begin
          cpu_we  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_valid && req_ready) begin
        addr_q  <= req_addr;
        write_q <= req_write;
      end
    end
  end

  assign s_acc = snp_valid && snp_ready;
  assign s_inv = s_acc && snp_write && s_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_rsp_valid <= 1'b0;
      snp_hit       <= 1'b0;
      snp_wb_needed <= 1'b0;
    end else begin
      snp_rsp_valid <= s_acc;
      snp_hit       <= s_acc && s_hit;
      snp_wb_needed <= s_acc && s_hit && snp_d && !snp_write;
    end
  end

endmodule

// File: rtl/l2dm_ctrl_chk.sv
module l2dm_ctrl_chk #(
  parameter int LA_W  = 12,
  parameter int IDX_W = 6,
  parameter int BEATS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     std_sram,
  input logic                     req_ready,
  input logic                     snp_valid,
  input logic                     snp_ready,
  input logic                     snp_rsp_valid,
  input logic                     snp_hit,
  input logic                     snp_wb_needed,
  input logic                     beat_o,
  input logic [$clog2(BEATS)-1:0] beat_idx,
  input logic                     sram_en,
  input logic                     sram_we,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic                     mem_req_wb,
  input logic [LA_W-1:0]          mem_req_addr
);
  localparam int DEPTH  = 1 << (IDX_W + 1);
  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] FINAL = BEAT_W'(BEATS - 1);
  localparam logic [CNT_W-1:0]  DLIM  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != DLIM) since_rst <= since_rst + 1'b1;
  end

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != DLIM) |-> (!req_ready && !snp_ready));

  p_burst_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_sram && beat_o && beat_idx != FINAL) |=> beat_o);

  p_std_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sram && beat_o) |=> !beat_o);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wb)));

  p_beat_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_o || sram_we) |-> sram_en);

  p_snp_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> snp_rsp_valid);

  p_snp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && snp_ready) |=> !snp_rsp_valid);

  p_wb_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_rsp_valid && snp_wb_needed) |-> snp_hit);

  p_idle_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sram_en && !mem_req_valid));

endmodule

bind l2dm_ctrl l2dm_ctrl_chk #(.LA_W(LA_W), .IDX_W(IDX_W), .BEATS(BEATS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .std_sram     (std_sram),
  .req_ready    (req_ready),
  .snp_valid    (snp_valid),
  .snp_ready    (snp_ready),
  .snp_rsp_valid(snp_rsp_valid),
  .snp_hit      (snp_hit),
  .snp_wb_needed(snp_wb_needed),
  .beat_o       (beat_o),
  .beat_idx     (beat_idx),
  .sram_en      (sram_en),
  .sram_we      (sram_we),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_wb   (mem_req_wb),
  .mem_req_addr (mem_req_addr)
);

// File: tb/l2dm_ctrl_tb_top.sv
module l2dm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LA_W  = 8;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << (IDX_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic size_big = 1'b0, std_sram = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LA_W-1:0] req_addr = '0;
  logic req_ready, beat_o, sram_en, sram_we;
  logic [1:0] beat_idx;
  logic mem_req_valid, mem_req_wb;
  logic mem_req_ready = 1'b0, mem_done = 1'b0;
  logic [LA_W-1:0] mem_req_addr;
  logic snp_valid = 1'b0, snp_write = 1'b0;
  logic [LA_W-1:0] snp_addr = '0;
  logic snp_ready, snp_rsp_valid, snp_hit, snp_wb_needed;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2dm_ctrl #(.LA_W(LA_W), .IDX_W(IDX_W), .BEATS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .size_big(size_big), .std_sram(std_sram),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .beat_o(beat_o), .beat_idx(beat_idx), .sram_en(sram_en), .sram_we(sram_we),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_wb(mem_req_wb),
    .mem_req_addr(mem_req_addr), .mem_done(mem_done),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr), .snp_write(snp_write),
    .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit), .snp_wb_needed(snp_wb_needed)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  bit       mv [DEPTH];
  bit       md [DEPTH];
  bit [4:0] mt [DEPTH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int midx(input logic [LA_W-1:0] a);
    return size_big ? int'(a[3:0]) : int'(a[2:0]);
  endfunction

  task automatic reset_cfg(input bit big, input bit std);
    @(negedge clk);
    rst_n = 1'b0;
    size_big = big;
    std_sram = std;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (DEPTH - 1) @(negedge clk);
    check(!req_ready && !snp_ready, "R1 ready low while clearing", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready && snp_ready, "R1 ready after clearing", int'(req_ready), 1);
    for (int i = 0; i < DEPTH; i++) begin
      mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0;
    end
  endtask

  task automatic do_req(input logic [LA_W-1:0] a, input bit wr, input string tag);
    int ix, cyc, nbeat, nmem, done_cnt, first, gap;
    int beats [4];
    bit mtype [2];
    logic [LA_W-1:0] maddr [2];
    bit exp_hit, exp_wb, en_bad, we_bad, idx_bad;
    logic [LA_W-1:0] victim;
    ix = midx(a);
    exp_hit = mv[ix] && (mt[ix] == a[7:3]);
    exp_wb  = !exp_hit && mv[ix] && md[ix];
    victim  = {mt[ix], 3'(ix)};
    while (!req_ready) @(negedge clk);
    req_addr = a; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 2; nbeat = 0; nmem = 0; done_cnt = -1;
    en_bad = 1'b0; we_bad = 1'b0; idx_bad = 1'b0;
    while (nbeat < 4 && cyc < 300) begin
      if (beat_o) begin
        if (beat_idx != 2'(nbeat)) idx_bad = 1'b1;
        if (sram_we != wr) we_bad = 1'b1;
        beats[nbeat] = cyc;
        nbeat++;
      end
      if ((mem_req_valid || done_cnt >= 0) && sram_en) en_bad = 1'b1;
      if (mem_req_valid && !mem_req_ready) begin
        if (nmem < 2) begin
          mtype[nmem] = mem_req_wb;
          maddr[nmem] = mem_req_addr;
        end
        nmem++;
        mem_req_ready = 1'b1;
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        done_cnt = 3;
      end
      if (done_cnt == 0) begin
        mem_done = 1'b1;
        done_cnt = -1;
      end else begin
        mem_done = 1'b0;
        if (done_cnt > 0) done_cnt--;
      end
      @(negedge clk);
      cyc++;
    end
    mem_done = 1'b0;
    check(nbeat == 4, {"R9 four beats ", tag}, nbeat, 4);
    check(!idx_bad && !we_bad, {"R9 beat index/we ", tag}, int'(idx_bad || we_bad), 0);
    check(!en_bad, {"R9 sram standby during memory wait ", tag}, int'(en_bad), 0);
    check(req_ready && !sram_en, {"R13 idle after beats ", tag}, int'(req_ready), 1);
    gap = std_sram ? 2 : 1;
    if (exp_hit) begin
      check(nmem == 0, {"R3 hit raises no memory request ", tag}, nmem, 0);
      first = (std_sram && wr) ? 4 : 3;
      for (int k = 0; k < 4; k++)
        check(beats[k] == first + k * gap, std_sram ? {"R5 beat cycle ", tag} : {"R4 beat cycle ", tag},
              beats[k], first + k * gap);
    end else begin
      for (int k = 1; k < 4; k++)
        check(beats[k] - beats[k-1] == gap, {"R5 replay spacing ", tag}, beats[k] - beats[k-1], gap);
      if (exp_wb) begin
        check(nmem == 2, {"R7 writeback then fill count ", tag}, nmem, 2);
        check(mtype[0] == 1'b1 && maddr[0] == victim, {"R7 writeback address ", tag}, int'(maddr[0]), int'(victim));
        check(mtype[1] == 1'b0 && maddr[1] == a, {"R7 fill after writeback ", tag}, int'(maddr[1]), int'(a));
      end else begin
        check(nmem == 1, {"R6 single fill ", tag}, nmem, 1);
        check(mtype[0] == 1'b0 && maddr[0] == a, {"R6 fill address ", tag}, int'(maddr[0]), int'(a));
      end
      mv[ix] = 1'b1; md[ix] = 1'b0; mt[ix] = a[7:3];
    end
    if (wr) md[ix] = 1'b1;
  endtask

  task automatic do_snoop(input logic [LA_W-1:0] a, input bit wr, input string tag);
    int ix;
    bit eh, ew;
    ix = midx(a);
    eh = mv[ix] && (mt[ix] == a[7:3]);
    ew = eh && md[ix] && !wr;
    while (!snp_ready) @(negedge clk);
    snp_addr = a; snp_write = wr; snp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    check(snp_rsp_valid == 1'b1, {"R10 response next cycle ", tag}, int'(snp_rsp_valid), 1);
    check(snp_hit == eh, {"R10 snoop hit ", tag}, int'(snp_hit), int'(eh));
    check(snp_wb_needed == ew, wr ? {"R11 snoop write wb flag ", tag} : {"R12 snoop read wb flag ", tag},
          int'(snp_wb_needed), int'(ew));
    if (wr && eh) mv[ix] = 1'b0;
    @(negedge clk);
    check(snp_rsp_valid == 1'b0, {"R10 response one cycle ", tag}, int'(snp_rsp_valid), 0);
  endtask

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      reset_cfg(cfg[1], cfg[0]);
      for (int i = 0; i < (cfg[1] ? 16 : 8); i++) begin
        logic [3:0] ha, hb;
        logic [LA_W-1:0] a, b, alias_a;
        ha = 4'((i * 3 + cfg) & 15);
        hb = ha ^ 4'b1010;
        a = {ha, (cfg[1] ? i[3] : ~i[0]), i[2:0]};
        b = {hb, (cfg[1] ? i[3] : ~i[0]), i[2:0]};
        do_req(a, 1'b0, "R6 clean miss");
        do_req(a, 1'b0, "R3 read hit");
        do_req(a, 1'b1, "R3 write hit");
        do_snoop(a, 1'b0, "R12 dirty read probe");
        do_snoop(a, 1'b0, "R12 probe leaves line");
        do_req(b, 1'b0, "R7 dirty miss");
        do_req(b, 1'b1, "R3 write hit b");
        do_snoop(b, 1'b1, "R11 invalidate");
        do_snoop(b, 1'b0, "R11 gone after invalidate");
        do_req(b, 1'b1, "R6 write miss");
        do_snoop(a, 1'b0, "R10 evicted probe");
        if (!cfg[1]) begin
          alias_a = b ^ 8'h08;
          do_req(alias_a, 1'b0, "R2 alias eviction");
        end
      end
      repeat (3) @(negedge clk);
      check(!sram_en && req_ready, "R9 standby when idle", int'(sram_en), 0);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule